// File: doc/BRIEF.md
# One-Hot Control Sequencer with Shared Subroutine

This block is a synchronous control sequencer. Its program counter is unary: each state is a single flip-flop, and exactly one of them holds the token at any time. On each clock edge the token moves to a successor state. The successor is chosen from the current state and a few condition inputs, so the flip-flop chain behaves like a shift register that can also branch and loop. Every state appears on the state vector output, and that vector is the set of per-state control strobes. A few named strobes are also brought out separately for convenience.

Several call sites share one subroutine, for example a memory access sequence. When a call site is entered, it sets its own return flag. The entry token of the subroutine is the OR of all call-site tokens. On the final step of the subroutine, the token is ANDed with each return flag. Only the continuation state of the caller receives the token, and that caller's flag is cleared at the same time. No binary return register or stack is used.

The main flow has a fixed chain of plain delay stages. An operation started in one state is complete after a known number of stages, so a later state can use its result. A token-error flag is raised whenever the number of active states is anything other than one.

Top module: `onehot_subr_seq`

## Requirements
- R1: During reset, and on the first cycle after it, state_vec has only bit 0 (the idle state) set, and token_err is 0.
- R2: After every clock edge, state_vec has exactly one bit set and token_err is 0.
- R3: The idle state (bit 0) keeps the token while go is 0. With go at 1, the token moves to call site 0 (bit 1) at the next edge.
- R4: Call site k is state bit 1+k. From any call site, the token moves to the first subroutine step (bit 1+2*N_CALL) at the next edge.
- R5: Subroutine step j is bit 1+2*N_CALL+j. Each step advances to the next one. The last step holds the token while mem_ready is 0.
- R6: When mem_ready is 1 on the last subroutine step, the token moves only to the continuation state (bit 1+N_CALL+k) of the call site k that made the most recent call.
- R7: A return flag is cleared when control returns to its call site. A later call from a different site therefore returns only to that later site.
- R8: In continuation state k, rep_req at 1 sends the token back to call site k. rep_req at 0 sends it to call site k+1, or to the first delay stage when k is the last site.
- R9: The delay stages (bits 1+2*N_CALL+SUB_LEN onward) each pass the token on. The token reaches the done state (the top bit) after DLY_LEN stages, and moves from done to idle.
- R10: call_stb[k] is high exactly while call site k holds the token. sub_issue is high exactly on the first subroutine step. seq_done is high exactly in the done state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start condition sampled in the idle state |
| rep_req | input | 1 | Loop-back condition sampled in continuation states |
| mem_ready | input | 1 | Completion condition sampled on the last subroutine step |
| state_vec | output | N_STATE | One-hot state vector; each bit is that state's strobe |
| call_stb | output | N_CALL | High while the matching call site holds the token |
| sub_issue | output | 1 | High on the first subroutine step |
| seq_done | output | 1 | High in the done state |
| token_err | output | 1 | High when the active-state count is not one |

## Verification
A wrong internal state shows up on the state vector at the very next clock edge. A lost or duplicated token changes the population count of state_vec and raises token_err in the same cycle. A stale or missing return flag shows up one edge after the subroutine completes: the token either lands in the wrong continuation state or appears in two continuations at once. The bench compares the full state vector and strobes against a reference model after every edge, so any divergence is caught in the cycle it occurs.

// File: rtl/seq_pkg.sv
package seq_pkg;
   // Total state count from the sizing parameters:
   // idle + calls + continuations + subroutine steps + delay stages + done
   function automatic int seq_state_count(input int n_call, input int sub_len, input int dly_len);
      return 2 * n_call + sub_len + dly_len + 2;
   endfunction
endpackage

// File: rtl/seq_sub_chain.sv
module seq_sub_chain #(
   parameter int SUB_LEN = 3
) (
   input  logic               entry_tok,
   input  logic               mem_ready,
   input  logic [SUB_LEN-1:0] cur,
   output logic [SUB_LEN-1:0] nxt,
   output logic               ret_pulse
);
   localparam int LAST = SUB_LEN - 1;

   if (SUB_LEN < 2) begin : g_len_bad
      $error("seq_sub_chain: SUB_LEN must be at least 2");
   end

   assign nxt[0] = entry_tok;

   for (genvar j = 1; j < LAST; j++) begin : g_step
      assign nxt[j] = cur[j-1];
   end

   // last step waits for completion
   assign nxt[LAST]  = cur[LAST-1] | (cur[LAST] & ~mem_ready);
   assign ret_pulse  = cur[LAST] & mem_ready;
endmodule

// File: rtl/seq_return_flags.sv
module seq_return_flags #(
   parameter int N_CALL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CALL-1:0] call_tok,
   input  logic              ret_pulse,
   output logic [N_CALL-1:0] cont_tok
);
   logic [N_CALL-1:0] flag_q;

   for (genvar k = 0; k < N_CALL; k++) begin : g_site
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q[k] <= 1'b0;
         else if (call_tok[k])
            flag_q[k] <= 1'b1;
         else if (ret_pulse)
            flag_q[k] <= 1'b0;
      end

      assign cont_tok[k] = ret_pulse & flag_q[k];

      // R6
      call_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         call_tok[k] |=> flag_q[k]);
   end

   // R7
   flags_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_q));

   // R6
   return_has_caller_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pulse |-> (flag_q != '0));

   // R7
   return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_pulse |=> (flag_q == '0));
endmodule

// File: rtl/seq_token_monitor.sv
module seq_token_monitor #(
   parameter int N_STATE = 13
) (
   input  logic [N_STATE-1:0] state,
   output logic               err
);
   localparam int CW = $clog2(N_STATE + 1);
   logic [CW-1:0] cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < N_STATE; i++)
         cnt = cnt + CW'(state[i]);
   end

   assign err = (cnt != CW'(1));
endmodule

// File: rtl/onehot_subr_seq.sv
module onehot_subr_seq
   import seq_pkg::*;
#(
   parameter  int N_CALL  = 3,
   parameter  int SUB_LEN = 3,
   parameter  int DLY_LEN = 2,
   localparam int N_STATE = seq_state_count(N_CALL, SUB_LEN, DLY_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               rep_req,
   input  logic               mem_ready,
   output logic [N_STATE-1:0] state_vec,
   output logic [N_CALL-1:0]  call_stb,
   output logic               sub_issue,
   output logic               seq_done,
   output logic               token_err
);
   localparam int S_IDLE  = 0;
   localparam int S_CALL  = 1;
   localparam int S_CONT  = 1 + N_CALL;
   localparam int S_SUB   = 1 + 2 * N_CALL;
   localparam int S_DLY   = S_SUB + SUB_LEN;
   localparam int S_DONE  = N_STATE - 1;
   localparam int SUB_END = S_SUB + SUB_LEN - 1;

   if (N_CALL < 1) begin : g_call_bad
      $error("onehot_subr_seq: N_CALL must be at least 1");
   end
   if (DLY_LEN < 1) begin : g_dly_bad
      $error("onehot_subr_seq: DLY_LEN must be at least 1");
   end

   logic [N_STATE-1:0] st_q, st_d;
   logic [N_CALL-1:0]  call_tok, cont_tok, cont_cur;
   logic [SUB_LEN-1:0] sub_cur, sub_nxt;
   logic               ret_pulse;

   assign call_tok = st_q[S_CALL +: N_CALL];
   assign cont_cur = st_q[S_CONT +: N_CALL];
   assign sub_cur  = st_q[S_SUB +: SUB_LEN];

   seq_sub_chain #(.SUB_LEN(SUB_LEN)) u_sub (
      .entry_tok (|call_tok),
      .mem_ready (mem_ready),
      .cur       (sub_cur),
      .nxt       (sub_nxt),
      .ret_pulse (ret_pulse)
   );

   seq_return_flags #(.N_CALL(N_CALL)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .call_tok  (call_tok),
      .ret_pulse (ret_pulse),
      .cont_tok  (cont_tok)
   );

   seq_token_monitor #(.N_STATE(N_STATE)) u_mon (
      .state (st_q),
      .err   (token_err)
   );

   // next-token gates
   assign st_d[S_IDLE] = (st_q[S_IDLE] & ~go) | st_q[S_DONE];
   assign st_d[S_CALL] = (st_q[S_IDLE] & go) | (cont_cur[0] & rep_req);

   for (genvar k = 1; k < N_CALL; k++) begin : g_call
      assign st_d[S_CALL+k] = (cont_cur[k-1] & ~rep_req) | (cont_cur[k] & rep_req);
   end

   assign st_d[S_CONT +: N_CALL]  = cont_tok;
   assign st_d[S_SUB +: SUB_LEN]  = sub_nxt;
   assign st_d[S_DLY] = cont_cur[N_CALL-1] & ~rep_req;

   for (genvar j = 1; j < DLY_LEN; j++) begin : g_dly
      assign st_d[S_DLY+j] = st_q[S_DLY+j-1];
   end

   assign st_d[S_DONE] = st_q[S_DLY+DLY_LEN-1];

   always_ff @(posedge clk) begin
      if (!rst_n)
         st_q <= N_STATE'(1) << S_IDLE;
      else
         st_q <= st_d;
   end

   assign state_vec = st_q;
   assign call_stb  = call_tok;
   assign sub_issue = st_q[S_SUB];
   assign seq_done  = st_q[S_DONE];

   // R2
   token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st_q) == 1);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[S_IDLE] && !go) |=> st_q[S_IDLE]);

   // R4
   call_enters_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_tok != '0) |=> st_q[S_SUB]);

   // R5
   sub_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[SUB_END] && !mem_ready) |=> st_q[SUB_END]);

   // R9
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[S_DONE] |=> st_q[S_IDLE]);
endmodule

// File: tb/onehot_subr_seq_bench.sv
`timescale 1ns/1ps
module onehot_subr_seq_bench;
   localparam int N  = 3;
   localparam int L  = 3;
   localparam int D  = 2;
   localparam int NS = 2 * N + L + D + 2;
   localparam int I_CALL = 1;
   localparam int I_CONT = 1 + N;
   localparam int I_SUB  = 1 + 2 * N;
   localparam int I_DLY  = I_SUB + L;
   localparam int I_DONE = NS - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0, rep_req = 1'b0, mem_ready = 1'b0;
   logic [NS-1:0] state_vec;
   logic [N-1:0]  call_stb;
   logic sub_issue, seq_done, token_err;

   int checks = 0;
   int errors = 0;
   int exp_idx = 0;
   int exp_site = -1;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   onehot_subr_seq u_onehot_subr_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .rep_req(rep_req), .mem_ready(mem_ready),
      .state_vec(state_vec), .call_stb(call_stb), .sub_issue(sub_issue),
      .seq_done(seq_done), .token_err(token_err)
   );

   // requirement tag for a check made while the token sits in state idx
   function automatic string tag_of(input int idx);
      if (idx == 0)                      return "R3";
      if (idx < I_CONT)                  return "R4";
      if (idx < I_SUB)                   return "R8";
      if (idx < I_DLY)                   return (idx == I_DLY - 1) ? "R6" : "R5";
      return "R9";
   endfunction

   function automatic int model_next(input int idx, input logic g, input logic r, input logic m);
      if (idx == 0)          return g ? I_CALL : 0;
      if (idx < I_CONT)      return I_SUB;
      if (idx < I_SUB) begin
         int k = idx - I_CONT;
         if (r)               return I_CALL + k;
         if (k < N - 1)       return I_CALL + k + 1;
         return I_DLY;
      end
      if (idx < I_DLY - 1)   return idx + 1;
      if (idx == I_DLY - 1)  return m ? (I_CONT + exp_site) : idx;
      if (idx == I_DONE)     return 0;
      return idx + 1;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      logic [NS-1:0] ev;
      logic [N-1:0]  ec;
      ev = NS'(1) << exp_idx;
      for (int k = 0; k < N; k++) ec[k] = (exp_idx == I_CALL + k);
      check(req, 64'(state_vec), 64'(ev));
      check("R2", 64'(token_err), 64'd0);
      check("R10", 64'({call_stb, sub_issue, seq_done}),
            64'({ec, exp_idx == I_SUB, exp_idx == I_DONE}));
   endtask

   // drive inputs at negedge, advance one edge, compare at the next negedge
   task automatic step(input logic g, input logic r, input logic m);
      string t;
      go = g; rep_req = r; mem_ready = m;
      t = tag_of(exp_idx);
      if (exp_idx >= I_CALL && exp_idx < I_CONT) exp_site = exp_idx - I_CALL;
      exp_idx = model_next(exp_idx, g, r, m);
      @(negedge clk);
      check_all(t);
   endtask

   initial begin
      void'($urandom(32'd1966));
      repeat (3) @(negedge clk);
      check("R1", 64'(state_vec), 64'd1);
      check("R1", 64'(token_err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // directed: idle holds, then full pass with long waits and a loop
      repeat (4) step(0, 0, 0);          // R3
      step(1, 0, 0);                     // enter call 0
      step(0, 0, 0);                     // R4 into subroutine
      step(0, 0, 0);
      repeat (5) step(0, 0, 0);          // R5 wait on last step
      step(0, 0, 1);                     // R6 return to cont 0
      step(0, 1, 0);                     // R8 loop back to call 0
      step(0, 0, 1);
      step(0, 0, 1);
      step(0, 0, 1);
      step(0, 0, 1);                     // return to cont 0 again
      step(0, 0, 1);                     // R8 on to call 1
      step(0, 0, 1);
      step(0, 0, 1);
      step(0, 0, 1);
      step(0, 0, 1);                     // R7 must land in cont 1 only
      step(0, 0, 0);                     // call 2
      repeat (4) step(0, 0, 1);          // return to cont 2
      step(0, 0, 0);                     // R9 delay chain
      repeat (D + 1) step(0, 0, 0);      // done then idle

      // constrained random
      for (int i = 0; i < 4000; i++)
         step(($urandom % 2) == 0, ($urandom % 4) == 0, ($urandom % 5) < 2);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule